// File: doc/BRIEF.md
# Stuck-Dominant Transmit Guard

This block sits between a protocol controller's transmit line and the driver of a single-wire bus. A low transmit level means dominant and a high level means recessive. The block samples the transmit line on every clock and counts how long it has stayed low without a break. If that run reaches a limit set in clock cycles, the block latches a mute. The driver then stays recessive until the transmit line is seen to rise again. Until that rise, further low time has no effect.

The block also folds three conditions into one driver-enable output: a permit from the operating-mode logic, an undervoltage flag and an over-temperature flag. Either fault flag mutes the driver for as long as it is raised. The flags cause no mode change and no report. Undervoltage and a missing mode permit also drop the receiver enable. Whenever the driver is not enabled, the value sent toward the bus is recessive. Temperature and supply sensing happen elsewhere and arrive here as clean digital flags.

Top module: `txd_dom_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_tx_o` is 1 (recessive) and `drv_en_o` follows only the permit and fault inputs.
- R2: With `mode_ok_i`=1 and both fault flags 0, `bus_tx_o` equals the value of `txd_i` sampled at the previous rising clock edge, and `drv_en_o` is 1. On `txd_i`, 0 means dominant and 1 means recessive.
- R3: After `TIMEOUT_CYC` consecutive low samples of `txd_i`, the edge that follows forces `drv_en_o` to 0 and `bus_tx_o` to 1, even if `txd_i` stays low.
- R4: A low run shorter than `TIMEOUT_CYC` samples is never muted. A single high sample restarts the count from zero.
- R5: Once muted by the timeout, the block stays muted while `txd_i` stays low. It releases within two clock edges after `txd_i` is first sampled high, and low samples after that are driven dominant again.
- R6: While `ot_flag_i`=1, `drv_en_o` is 0 and `bus_tx_o` is 1. `rx_en_o` is unaffected, and transmission resumes on the cycle the flag clears.
- R7: While `uv_flag_i`=1, `drv_en_o` and `rx_en_o` are both 0 and `bus_tx_o` is 1. Both enables resume when the flag clears.
- R8: While `mode_ok_i`=0, `drv_en_o` and `rx_en_o` are 0 and `bus_tx_o` is 1.
- R9: A timeout mute latched while a fault flag was raised is still in force after the flag clears, until `txd_i` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data from the controller; 0 dominant, 1 recessive |
| mode_ok_i | input | 1 | Operating mode permits transmit and receive |
| uv_flag_i | input | 1 | Supply undervoltage flag |
| ot_flag_i | input | 1 | Over-temperature flag |
| drv_en_o | output | 1 | Bus driver enable |
| bus_tx_o | output | 1 | Value sent to the driver; 1 whenever the driver is disabled |
| rx_en_o | output | 1 | Receiver stage enable |

## Verification
The guard is driven with several kinds of low run on the transmit line:
- A run of exactly the limit shows where the mute takes effect, to the cycle.
- A run one sample short, broken by a single high sample and then repeated at full length, separates a counter that restarts from one that accumulates.
- A run held far past the limit shows that the mute holds without a rising edge and releases after one.

Fault flags are raised both alone and during a long low run. This separates the silent, level-following mute from the timeout latch, which persists after the flag clears.

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int TIMEOUT_CYC = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic mode_ok_i,
  input  logic uv_flag_i,
  input  logic ot_flag_i,
  output logic drv_en_o,
  output logic bus_tx_o,
  output logic rx_en_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

  logic          txd_q, txd_prev, mute_q;
  logic [CW-1:0] run_cnt;
  logic          rise, hit;

  assign rise = txd_q & ~txd_prev;
  assign hit  = ~txd_q & (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q    <= 1'b1;
      txd_prev <= 1'b1;
    end else begin
      txd_q    <= txd_i;
      txd_prev <= txd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (txd_q)          run_cnt <= '0;
    else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mute_q <= 1'b0;
    else if (rise)   mute_q <= 1'b0;
    else if (hit)    mute_q <= 1'b1;
  end

  assign drv_en_o = mode_ok_i & ~uv_flag_i & ~ot_flag_i & ~mute_q;
  assign bus_tx_o = drv_en_o ? txd_q : 1'b1;
  assign rx_en_o  = mode_ok_i & ~uv_flag_i;

  p_recessive_reset_r1: assert property (@(posedge clk)
    !rst_n |=> bus_tx_o);

  p_mute_on_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!drv_en_o && bus_tx_o));

  p_count_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txd_q |=> (run_cnt == '0));

  p_hold_until_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && !rise) |=> mute_q);

  p_release_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && rise) |=> !mute_q);

  p_ot_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag_i |-> (!drv_en_o && bus_tx_o));

  p_uv_both_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag_i |-> (!drv_en_o && !rx_en_o));

  p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok_i |-> (!drv_en_o && !rx_en_o && bus_tx_o));
endmodule

// File: tb/sim_txd_dom_guard.sv
module sim_txd_dom_guard;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, mode_ok = 1'b1, uv = 1'b0, ot = 1'b0;
  logic drv_en, bus_tx, rx_en;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .mode_ok_i(mode_ok),
    .uv_flag_i(uv), .ot_flag_i(ot), .drv_en_o(drv_en),
    .bus_tx_o(bus_tx), .rx_en_o(rx_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_high(input int n);
    txd = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 bus in reset", bus_tx, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 bus after reset", bus_tx, 1'b1);
    chk("R1 drv_en after reset", drv_en, 1'b1);
  endtask

  task automatic t_pass();
    logic [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      txd = pat[i];
      @(negedge clk);
      chk("R2 follow txd", bus_tx, pat[i]);
      chk("R2 drv_en", drv_en, 1'b1);
    end
    idle_high(2);
  endtask

  task automatic t_timeout();
    txd = 1'b0;
    for (int i = 0; i < TO; i++) begin
      @(negedge clk);
      chk("R3 dominant before limit", bus_tx, 1'b0);
    end
    @(negedge clk);
    chk("R3 muted at limit", bus_tx, 1'b1);
    chk("R3 drv_en off", drv_en, 1'b0);
    for (int i = 0; i < 3 * TO; i++) @(negedge clk);
    chk("R5 mute held while low", drv_en, 1'b0);
    txd = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 released after rise", drv_en, 1'b1);
    txd = 1'b0;
    @(negedge clk);
    chk("R5 dominant after release", bus_tx, 1'b0);
    idle_high(2);
  endtask

  task automatic t_short();
    txd = 1'b0;
    for (int i = 0; i < TO - 1; i++) @(negedge clk);
    chk("R4 short run still dominant", bus_tx, 1'b0);
    txd = 1'b1;
    @(negedge clk);
    txd = 1'b0;
    for (int i = 0; i < TO; i++) begin
      @(negedge clk);
      chk("R4 restart full run dominant", bus_tx, 1'b0);
    end
    @(negedge clk);
    chk("R4 restarted run muted at limit", bus_tx, 1'b1);
    idle_high(3);
  endtask

  task automatic t_ot();
    txd = 1'b0; ot = 1'b1;
    @(negedge clk);
    chk("R6 ot drv_en off", drv_en, 1'b0);
    chk("R6 ot bus recessive", bus_tx, 1'b1);
    chk("R6 ot rx untouched", rx_en, 1'b1);
    ot = 1'b0;
    #1;
    chk("R6 resume on clear", bus_tx, 1'b0);
    idle_high(2);
  endtask

  task automatic t_uv();
    uv = 1'b1;
    @(negedge clk);
    chk("R7 uv drv_en off", drv_en, 1'b0);
    chk("R7 uv rx off", rx_en, 1'b0);
    uv = 1'b0;
    #1;
    chk("R7 uv rx resumes", rx_en, 1'b1);
    chk("R7 uv drv resumes", drv_en, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_mode();
    mode_ok = 1'b0; txd = 1'b0;
    @(negedge clk);
    chk("R8 mode drv_en off", drv_en, 1'b0);
    chk("R8 mode rx off", rx_en, 1'b0);
    chk("R8 mode bus recessive", bus_tx, 1'b1);
    mode_ok = 1'b1;
    idle_high(2);
  endtask

  task automatic t_fault_latch();
    txd = 1'b0; ot = 1'b1;
    for (int i = 0; i < TO + 3; i++) @(negedge clk);
    ot = 1'b0;
    @(negedge clk);
    chk("R9 mute survives ot clear", drv_en, 1'b0);
    chk("R9 bus recessive", bus_tx, 1'b1);
    txd = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 released by rise", drv_en, 1'b1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    idle_high(2);
    t_pass();
    t_timeout();
    t_short();
    t_ot();
    t_uv();
    t_mode();
    t_fault_latch();
    finish_run();
  end
endmodule